// File: doc/BRIEF.md
# Host-Bus Error Flag Register

This block is an 8-bit status and control register on the slave processor's register bus. It lets the slave CPU see two events from the host bus. The events are a falling edge on the active-low bus-reset pin and a falling edge on the active-low power-down pin. Each event latches a sticky flag, and either flag drives a shared error interrupt toward the slave CPU. Software acknowledges a flag in two steps: it must first read the register and see that flag at one, and only then can it write zero to the flag. A plain write of zero does not clear it.

Bit 7 is a read-only view of the gate-A20 pin. It shows the pin level after synchronization, whatever the rest of the host interface is doing. Bit 0 is a read/write control bit. It is ANDed with an external enable to drive a system-control-interrupt output. The power-down flag has one more clear path: a host-bus hardware reset (bus-reset pin held low) or a software reset pulse clears it.

Top module: `hbus_errflag`

## Requirements
- R1: After reset the flags (bit 6 and bit 5), the control bit (bit 0) and `err_irq` are 0.
- R2: A falling edge on `busrst_n` sets the reset flag in bit 6. The flag reads 1 at the third rising clock edge after the pin changes.
- R3: A falling edge on `pwrdn_n` sets the power-down flag in bit 5, with the same latency as R2.
- R4: Writing 0 to a flag that has not been read as 1 since the last write leaves the flag at 1.
- R5: A read that returns a flag at 1 arms that flag. Any write disarms both flags. A write of 0 to an armed flag clears it.
- R6: Writing 1 to bit 6 or bit 5 has no effect on the flag.
- R7: If a set event and a valid clear fall in the same cycle, the flag stays at 1.
- R8: The power-down flag is cleared while the synchronized `busrst_n` is low, or when `sw_rst` is high. This clear has priority over a set event.
- R9: `err_irq` equals the OR of the two flags, delayed by one clock.
- R10: Bit 7 reads the `a20_pin` level two clock edges after it changes.
- R11: Bit 0 is read/write, and `sci_out` is bit 0 AND `sci_en`.
- R12: Bits 4 to 1 read 0. A pin held low produces only one set event, so a flag cleared while its pin stays low remains 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| busrst_n | input | 1 | Host bus reset pin, active low |
| pwrdn_n | input | 1 | Host bus power-down pin, active low |
| a20_pin | input | 1 | Gate-A20 pin to monitor |
| sw_rst | input | 1 | Host bus software reset pulse |
| sci_en | input | 1 | Enable for the SCI output |
| sci_out | output | 1 | System-control-interrupt output |
| err_irq | output | 1 | Error interrupt to the slave CPU |

## Verification
A pin edge goes through two synchronizer stages and one flag register, so a flag is due at the third rising edge after the pin moves. The interrupt is due one edge later, and the A20 monitor bit is due at the second edge. The bench drives pins and strobes on falling edges. It samples `rdata` shortly after a falling edge, and the interrupt test checks the cycle in which the flag is already 1 but `err_irq` is still 0. For the same-cycle conflict, the write strobe is placed in the exact cycle in which the set event is due.

// File: rtl/hbus_errflag_pkg.sv
package hbus_errflag_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_A20   = 7;
  localparam int BIT_RSTF  = 6;
  localparam int BIT_PDF   = 5;
  localparam int BIT_CTL   = 0;
  localparam int SYNC_DEF  = 2;
endpackage

// File: rtl/hbus_errflag_rstsync.sv
module hbus_errflag_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/hbus_errflag_pinsync.sv
module hbus_errflag_pinsync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = pin_i;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/hbus_errflag_flag.sv
module hbus_errflag_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic hard_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic soft_clr;

  always_comb begin
    soft_clr = wr_i & ~wbit_i & arm_q;
    if (hard_clr_i)    flag_d = 1'b0;
    else if (set_i)    flag_d = 1'b1;
    else if (soft_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
    if (wr_i)          arm_d = 1'b0;
    else if (rd_i)     arm_d = arm_q | flag_q;
    else               arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = arm_q;
endmodule

// File: rtl/hbus_errflag.sv
module hbus_errflag
  import hbus_errflag_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             busrst_n,
  input  logic             pwrdn_n,
  input  logic             a20_pin,
  input  logic             sw_rst,
  input  logic             sci_en,
  output logic             sci_out,
  output logic             err_irq
);
  logic srst_n;
  logic rst_lvl, rst_fall;
  logic pd_lvl, pd_fall;
  logic a20_lvl, a20_fall_unused;
  logic rstf, rstf_arm;
  logic pdf, pdf_arm;
  logic pd_hard_clr;
  logic ctl_q, ctl_d;
  logic irq_q, irq_d;

  hbus_errflag_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  hbus_errflag_pinsync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rst (
    .clk(clk), .rst_n(srst_n), .pin_i(busrst_n), .level_o(rst_lvl), .fall_o(rst_fall));

  hbus_errflag_pinsync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pd (
    .clk(clk), .rst_n(srst_n), .pin_i(pwrdn_n), .level_o(pd_lvl), .fall_o(pd_fall));

  hbus_errflag_pinsync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_a20 (
    .clk(clk), .rst_n(srst_n), .pin_i(a20_pin), .level_o(a20_lvl), .fall_o(a20_fall_unused));

  assign pd_hard_clr = ~rst_lvl | sw_rst;

  hbus_errflag_flag u_flag_rst (
    .clk(clk), .rst_n(srst_n), .set_i(rst_fall), .hard_clr_i(1'b0),
    .rd_i(rd_en), .wr_i(wr_en), .wbit_i(wdata[BIT_RSTF]),
    .flag_o(rstf), .armed_o(rstf_arm));

  hbus_errflag_flag u_flag_pd (
    .clk(clk), .rst_n(srst_n), .set_i(pd_fall), .hard_clr_i(pd_hard_clr),
    .rd_i(rd_en), .wr_i(wr_en), .wbit_i(wdata[BIT_PDF]),
    .flag_o(pdf), .armed_o(pdf_arm));

  always_comb begin
    ctl_d = wr_en ? wdata[BIT_CTL] : ctl_q;
    irq_d = rstf | pdf;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctl_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[BIT_A20]  = a20_lvl;
    rdata[BIT_RSTF] = rstf;
    rdata[BIT_PDF]  = pdf;
    rdata[BIT_CTL]  = ctl_q;
  end

  assign sci_out = ctl_q & sci_en;
  assign err_irq = irq_q;
endmodule

// File: rtl/hbus_errflag_chk.sv
module hbus_errflag_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       rst_fall,
  input logic       pd_fall,
  input logic       pd_hard_clr,
  input logic       rstf,
  input logic       pdf,
  input logic       rstf_arm,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       sci_en,
  input logic       sci_out,
  input logic       err_irq
);
  p_set_rst_r2: assert property (@(posedge clk) disable iff (!srst_n)
    rst_fall |=> rstf);
  p_set_pd_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (pd_fall && !pd_hard_clr) |=> pdf);
  p_no_spont_set_r4: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(rstf) |-> $past(rst_fall));
  p_clear_needs_arm_r5: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(rstf) |-> $past(wr_en && !wdata[6] && rstf_arm));
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!srst_n)
    rst_fall |=> rdata[6]);
  p_pd_hard_clr_r8: assert property (@(posedge clk) disable iff (!srst_n)
    pd_hard_clr |=> !pdf);
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!srst_n)
    err_irq == $past(rdata[6] || rdata[5]));
  p_zero_bits_r12: assert property (@(posedge clk) disable iff (!srst_n)
    rdata[4:1] == 4'b0000);
  p_sci_gate_r11: assert property (@(posedge clk) disable iff (!srst_n)
    sci_out == (sci_en && rdata[0]));
endmodule

bind hbus_errflag hbus_errflag_chk u_chk (
  .clk(clk), .srst_n(srst_n), .rst_fall(rst_fall), .pd_fall(pd_fall),
  .pd_hard_clr(pd_hard_clr), .rstf(rstf), .pdf(pdf), .rstf_arm(rstf_arm),
  .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .sci_en(sci_en),
  .sci_out(sci_out), .err_irq(err_irq));

// File: tb/hbus_errflag_test.sv
module hbus_errflag_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       busrst_n = 1'b1, pwrdn_n = 1'b1, a20_pin = 1'b0;
  logic       sw_rst = 1'b0, sci_en = 1'b0;
  logic       sci_out, err_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hbus_errflag uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .busrst_n(busrst_n), .pwrdn_n(pwrdn_n), .a20_pin(a20_pin),
    .sw_rst(sw_rst), .sci_en(sci_en), .sci_out(sci_out), .err_irq(err_irq));

  // kind: 0 write, 1 read-and-check, 2 busrst_n level, 3 pwrdn_n level, 4 a20 level
  // fields: kind[27:24] data[23:16] exp[15:8] req[7:0]
  localparam int NV = 24;
  localparam logic [27:0] VEC [NV] = '{
    {4'd1, 8'h00, 8'h00, 8'd1},   // R1 reset value
    {4'd0, 8'h01, 8'h00, 8'd11},  // R11 set control bit
    {4'd1, 8'h00, 8'h01, 8'd11},  // R11
    {4'd4, 8'h01, 8'h00, 8'd10},  // R10 a20 high
    {4'd1, 8'h00, 8'h81, 8'd10},  // R10
    {4'd0, 8'h60, 8'h00, 8'd6},   // R6 ones to flags
    {4'd1, 8'h00, 8'h80, 8'd6},   // R6
    {4'd2, 8'h00, 8'h00, 8'd2},   // R2 busrst falls
    {4'd0, 8'h00, 8'h00, 8'd4},   // R4 unarmed write 0
    {4'd1, 8'h00, 8'hC0, 8'd4},   // R4 still set, now armed
    {4'd0, 8'h00, 8'h00, 8'd5},   // R5 armed write 0
    {4'd1, 8'h00, 8'h80, 8'd5},   // R5 cleared
    {4'd1, 8'h00, 8'h80, 8'd12},  // R12 pin still low, no re-set
    {4'd2, 8'h01, 8'h00, 8'd12},  // busrst back high
    {4'd3, 8'h00, 8'h00, 8'd3},   // R3 pwrdn falls
    {4'd1, 8'h00, 8'hA0, 8'd3},   // R3 set and armed
    {4'd0, 8'h20, 8'h00, 8'd5},   // R5 any write disarms
    {4'd0, 8'h00, 8'h00, 8'd5},   // R5 write 0, not armed
    {4'd1, 8'h00, 8'hA0, 8'd5},   // R5 still set
    {4'd0, 8'h00, 8'h00, 8'd5},   // R5 armed again by read
    {4'd1, 8'h00, 8'h80, 8'd5},   // R5 cleared
    {4'd3, 8'h01, 8'h00, 8'd3},
    {4'd4, 8'h00, 8'h00, 8'd10},  // R10 a20 low
    {4'd1, 8'h00, 8'h00, 8'd10}   // R10
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = 8'h00;
  endtask

  task automatic do_read(input logic [7:0] exp, input int req);
    @(negedge clk); rd_en = 1'b1; #1;
    chk(rdata, exp, req);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    chk({7'd0, err_irq}, 8'h00, 1);  // R1 irq low after reset

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][27:24])
        4'd0: do_write(VEC[i][23:16]);
        4'd1: do_read(VEC[i][15:8], int'(VEC[i][7:0]));
        4'd2: begin @(negedge clk); busrst_n = VEC[i][16]; settle(); end
        4'd3: begin @(negedge clk); pwrdn_n  = VEC[i][16]; settle(); end
        default: begin @(negedge clk); a20_pin = VEC[i][16]; settle(); end
      endcase
    end

    // R9 and R2 latency: flag at third edge, irq one edge later
    @(negedge clk); busrst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk({rdata[6], err_irq}, 8'h02, 2);  // R2 flag set, R9 irq not yet
    @(posedge clk); @(negedge clk); #1;
    chk({7'd0, err_irq}, 8'h01, 9);      // R9
    @(negedge clk); busrst_n = 1'b1; settle();

    // R7: flag set and armed, then set event and valid clear in the same cycle
    do_read(8'h40, 7);
    @(negedge clk); busrst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); wr_en = 1'b1; wdata = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    do_read(8'h40, 7);                   // R7 set wins
    do_write(8'h00);                     // armed by read -> clears
    do_read(8'h00, 5);
    @(negedge clk); busrst_n = 1'b1; settle();
    @(negedge clk); #1;
    chk({7'd0, err_irq}, 8'h00, 9);      // R9 irq drops

    // R8 software reset clears power-down flag
    @(negedge clk); pwrdn_n = 1'b0; settle();
    do_read(8'h20, 3);
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0; #1;
    chk(rdata, 8'h00, 8);                // R8 sw reset
    @(negedge clk); pwrdn_n = 1'b1; settle();

    // R8 hardware bus reset clears power-down flag
    @(negedge clk); pwrdn_n = 1'b0; settle();
    do_read(8'h20, 3);
    @(negedge clk); busrst_n = 1'b0; settle();
    @(negedge clk); #1;
    chk(rdata, 8'h40, 8);                // R8 pd cleared, rst flag set
    @(negedge clk); pwrdn_n = 1'b1; busrst_n = 1'b1; settle();

    // R11 SCI output gating
    do_write(8'h01);
    @(negedge clk); sci_en = 1'b0; #1;
    chk({7'd0, sci_out}, 8'h00, 11);
    @(negedge clk); sci_en = 1'b1; #1;
    chk({7'd0, sci_out}, 8'h01, 11);

    // R1 reset in the middle of operation
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    chk({rdata[6:0], err_irq}, 8'h00, 1);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule